// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is a clocked model of the device side of the status read path of a parallel NOR flash. A start request for a program or an erase arrives with an address, a data byte and a flag that says whether the target is protected. The block then stays busy for a number of clock cycles set by a parameter. While it is busy, the read bus carries polling status on bit 7 and a ready output stays low. When the operation ends, the block goes back to plain reads. An erase can be suspended and later resumed. While an erase is suspended, one byte may be programmed outside the sector under erase.

A single storage slot holds the most recently programmed byte and its address, so the effect of an operation can be seen on the read bus. Any address that does not hit the slot reads as erased (0xFF). Bit 7 of the read bus follows `rd_addr` within the same cycle. Bits 6..0 come from a register, so they trail by one cycle: when bit 7 first shows true data, the low bits can still hold the old status value.

Top module: `nor_status_resp`

## Requirements
- R1: After reset, `ready` is 1 and a read at any address returns 0xFF.
- R2: A program request that is accepted while idle drives `ready` to 0 from the next cycle, for exactly PROG_CYC cycles, or PPROG_CYC cycles when protected.
- R3: While a program is busy, `rd_data[7]` is the inverse of bit 7 of the byte being programmed. From the second busy cycle onward, `rd_data[6:0]` is 0.
- R4: In the first ready cycle after a program, `rd_data[7]` carries the true value and `rd_data[6:0]` still reads 0. From the next cycle on, a read at the program address returns the programmed byte.
- R5: A protected program stays busy for PPROG_CYC cycles, polls like R3 and leaves the stored data unchanged.
- R6: An unprotected erase is busy for ERS_CYC cycles with `rd_data[7]` = 0. The erased sector is `addr[AW-1:AW-SECW]`. Afterwards a stored byte inside that sector reads 0xFF, and a stored byte outside it keeps its value.
- R7: A protected erase is busy for PERS_CYC cycles with `rd_data[7]` = 0 and changes no data.
- R8: A suspend request during an unprotected erase takes effect on the next cycle. `ready` goes to 1, and reads inside the erase sector return 0x80 once the lag has passed. A resume request restarts the erase, and the erase then uses its remaining cycles, so the total is ERS_CYC.
- R9: While suspended, a program outside the erase sector runs as in R2–R4 and then returns to the suspended state. A program inside the erase sector is ignored.
- R10: Requests that are not allowed in the current state are ignored. These are: an erase or a program during a busy operation, a suspend outside an unprotected erase, a resume outside the suspended state, and an erase while suspended.
- R11: A suspend request in the final busy cycle of an erase is ignored. The erase completes and the block returns to idle.
- R12: When a program request and an erase request arrive together in idle, the program wins. While suspended, a program request wins over a resume request.
- R13: In read mode, `rd_data[6:0]` reflects the `rd_addr` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_req | input | 1 | Program start request (one cycle) |
| ers_req | input | 1 | Erase start request (one cycle) |
| sus_req | input | 1 | Erase suspend request |
| res_req | input | 1 | Erase resume request |
| cmd_addr | input | AW | Target address of the request |
| cmd_data | input | 8 | Byte to program |
| cmd_prot | input | 1 | Target is protected |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data / polling status |
| ready | output | 1 | High when no program or erase is running |

## Verification
Two events can land in the same cycle: the erase counter running out and a suspend request. The bench raises `sus_req` exactly in the final busy cycle of an erase. It then reads a stored address inside that sector two cycles later. A completed erase gives 0xFF, while a suspend that wrongly wins gives 0x80. The same idea is used for simultaneous program and erase requests in idle, which are judged by the busy length and by the byte read afterwards.

// File: rtl/nsr_pkg.sv
// Shared types for the NOR status responder.
package nsr_pkg;
    // Controller states: idle, program busy, erase busy, erase suspended.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PGM  = 2'd1,
        ST_ERS  = 2'd2,
        ST_SUSP = 2'd3
    } nsr_state_e;
endpackage

// File: rtl/nsr_countdown.sv
// Loadable down-counter with a zero flag.
// Assumes load and dec are never needed together (load wins).
module nsr_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Counter register: load a start value, or step down by one.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nsr_ctrl.sv
// Operation controller: accepts requests, times program and erase,
// handles suspend/resume and issues commit strobes to the read path.
// Assumes requests are single-cycle pulses; disallowed ones are dropped.
module nsr_ctrl
    import nsr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int SECW      = 4,
    parameter int PROG_CYC  = 300,
    parameter int ERS_CYC   = 20000,
    parameter int PPROG_CYC = 50,
    parameter int PERS_CYC  = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pgm_req,
    input  logic            ers_req,
    input  logic            sus_req,
    input  logic            res_req,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [7:0]      cmd_data,
    input  logic            cmd_prot,
    output nsr_state_e      state,
    output logic [AW-1:0]   pgm_addr,
    output logic [7:0]      pgm_data,
    output logic [SECW-1:0] ers_sec,
    output logic            commit_pgm,
    output logic            commit_ers
);
    localparam int PMAX = (PROG_CYC > PPROG_CYC) ? PROG_CYC : PPROG_CYC;
    localparam int EMAX = (ERS_CYC > PERS_CYC) ? ERS_CYC : PERS_CYC;
    localparam int PW   = $clog2(PMAX + 1);
    localparam int EW   = $clog2(EMAX + 1);

    logic            pgm_prot, pgm_in_susp, ers_prot;
    logic            pgm_zero, ers_zero;
    logic            pgm_acc, ers_acc, sus_acc, res_acc;
    logic            pgm_done, ers_done;
    logic [SECW-1:0] cmd_sec;
    logic [PW-1:0]   pgm_len;
    logic [EW-1:0]   ers_len;

    // Request acceptance and completion decode.
    always_comb begin
        cmd_sec  = cmd_addr[AW-1 -: SECW];
        pgm_acc  = pgm_req && ((state == ST_IDLE) ||
                               (state == ST_SUSP && cmd_sec != ers_sec));
        ers_acc  = ers_req && (state == ST_IDLE) && !pgm_req;
        sus_acc  = sus_req && (state == ST_ERS) && !ers_prot && !ers_zero;
        res_acc  = res_req && (state == ST_SUSP) && !pgm_acc;
        pgm_done = (state == ST_PGM) && pgm_zero;
        ers_done = (state == ST_ERS) && ers_zero;
        pgm_len  = cmd_prot ? PW'(PPROG_CYC - 1) : PW'(PROG_CYC - 1);
        ers_len  = cmd_prot ? EW'(PERS_CYC - 1)  : EW'(ERS_CYC - 1);
    end

    assign commit_pgm = pgm_done && !pgm_prot;
    assign commit_ers = ers_done && !ers_prot;

    nsr_countdown #(.W(PW)) u_pgm_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pgm_acc),
        .load_val (pgm_len),
        .dec      ((state == ST_PGM) && !pgm_zero),
        .zero     (pgm_zero)
    );

    nsr_countdown #(.W(EW)) u_ers_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ers_acc),
        .load_val (ers_len),
        .dec      ((state == ST_ERS) && !ers_zero),
        .zero     (ers_zero)
    );

    // State register and capture of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            pgm_addr    <= '0;
            pgm_data    <= '0;
            pgm_prot    <= 1'b0;
            pgm_in_susp <= 1'b0;
            ers_sec     <= '0;
            ers_prot    <= 1'b0;
        end else begin
            if (pgm_acc) begin
                pgm_addr    <= cmd_addr;
                pgm_data    <= cmd_data;
                pgm_prot    <= cmd_prot;
                pgm_in_susp <= (state == ST_SUSP);
            end
            if (ers_acc) begin
                ers_sec  <= cmd_sec;
                ers_prot <= cmd_prot;
            end
            case (state)
                ST_IDLE: if (pgm_acc) state <= ST_PGM;
                         else if (ers_acc) state <= ST_ERS;
                ST_PGM:  if (pgm_done) state <= pgm_in_susp ? ST_SUSP : ST_IDLE;
                ST_ERS:  if (ers_done) state <= ST_IDLE;
                         else if (sus_acc) state <= ST_SUSP;
                ST_SUSP: if (pgm_acc) state <= ST_PGM;
                         else if (res_acc) state <= ST_ERS;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nsr_readpath.sv
// Read path: one stored byte slot, polling-status mux on bit 7 and a
// one-cycle register on bits 6..0. Assumes commit strobes never coincide.
module nsr_readpath
    import nsr_pkg::*;
#(
    parameter int AW   = 12,
    parameter int SECW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  nsr_state_e      state,
    input  logic [AW-1:0]   pgm_addr,
    input  logic [7:0]      pgm_data,
    input  logic [SECW-1:0] ers_sec,
    input  logic            commit_pgm,
    input  logic            commit_ers,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data
);
    logic          st_valid;
    logic [AW-1:0] st_addr;
    logic [7:0]    st_data;
    logic [6:0]    low_q;
    logic [7:0]    true_byte;
    logic          show, stat_b7;

    // Stored byte slot: written by a program, cleared by an erase of its sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_addr  <= '0;
            st_data  <= 8'hFF;
        end else if (commit_pgm) begin
            st_valid <= 1'b1;
            st_addr  <= pgm_addr;
            st_data  <= pgm_data;
        end else if (commit_ers && st_addr[AW-1 -: SECW] == ers_sec) begin
            st_valid <= 1'b0;
        end
    end

    // Array view and status selection for the current read address.
    always_comb begin
        true_byte = (st_valid && rd_addr == st_addr) ? st_data : 8'hFF;
        show      = 1'b0;
        stat_b7   = 1'b1;
        case (state)
            ST_PGM:  begin show = 1'b1; stat_b7 = ~pgm_data[7]; end
            ST_ERS:  begin show = 1'b1; stat_b7 = 1'b0; end
            ST_SUSP: begin show = (rd_addr[AW-1 -: SECW] == ers_sec); stat_b7 = 1'b1; end
            default: begin show = 1'b0; stat_b7 = 1'b1; end
        endcase
    end

    // Low data bits trail by one cycle; zero while status is shown.
    always_ff @(posedge clk) begin
        if (!rst_n)    low_q <= 7'h7F;
        else if (show) low_q <= '0;
        else           low_q <= true_byte[6:0];
    end

    assign rd_data = {show ? stat_b7 : true_byte[7], low_q};
endmodule

// File: rtl/nor_status_resp.sv
// Top of the NOR program/erase status responder.
// Assumes all requests are synchronous to clk; timing windows in cycles.
module nor_status_resp
    import nsr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int SECW      = 4,
    parameter int PROG_CYC  = 300,
    parameter int ERS_CYC   = 20000,
    parameter int PPROG_CYC = 50,
    parameter int PERS_CYC  = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgm_req,
    input  logic          ers_req,
    input  logic          sus_req,
    input  logic          res_req,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic          cmd_prot,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          ready
);
    nsr_state_e      state;
    logic [AW-1:0]   pgm_addr;
    logic [7:0]      pgm_data;
    logic [SECW-1:0] ers_sec;
    logic            commit_pgm, commit_ers;

    nsr_ctrl #(
        .AW(AW), .SECW(SECW), .PROG_CYC(PROG_CYC), .ERS_CYC(ERS_CYC),
        .PPROG_CYC(PPROG_CYC), .PERS_CYC(PERS_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pgm_req(pgm_req), .ers_req(ers_req), .sus_req(sus_req), .res_req(res_req),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
        .state(state), .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_sec(ers_sec),
        .commit_pgm(commit_pgm), .commit_ers(commit_ers)
    );

    nsr_readpath #(.AW(AW), .SECW(SECW)) u_rd (
        .clk(clk), .rst_n(rst_n), .state(state),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_sec(ers_sec),
        .commit_pgm(commit_pgm), .commit_ers(commit_ers),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign ready = (state == ST_IDLE) || (state == ST_SUSP);
endmodule

// File: rtl/nsr_checker.sv
// Temporal checks on the responder, attached by bind.
module nsr_checker
    import nsr_pkg::*;
#(
    parameter int AW   = 12,
    parameter int SECW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pgm_req,
    input logic            ers_req,
    input logic            res_req,
    input logic [AW-1:0]   rd_addr,
    input logic [7:0]      rd_data,
    input logic            ready,
    input nsr_state_e      state,
    input logic [7:0]      pgm_data,
    input logic [SECW-1:0] ers_sec
);
    AST_PGM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pgm_req) |=> (!ready && state == ST_PGM)); // R2
    AST_PGM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM) |-> (rd_data[7] == ~pgm_data[7])); // R3
    AST_LOW_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> (rd_data[6:0] == 7'd0)); // R3
    AST_ERS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS) |-> (rd_data[7] == 1'b0)); // R6
    AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && rd_addr[AW-1 -: SECW] == ers_sec) |-> rd_data[7]); // R8
    AST_BUSY_NO_ERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM && ers_req) |=> (state != ST_ERS)); // R10
    AST_IDLE_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && res_req && !pgm_req && !ers_req) |=> (state == ST_IDLE)); // R10
endmodule

bind nor_status_resp nsr_checker #(.AW(AW), .SECW(SECW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .ers_req(ers_req),
    .res_req(res_req), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready),
    .state(state), .pgm_data(pgm_data), .ers_sec(ers_sec)
);

// File: tb/sim_nor_status_resp.sv
`timescale 1ns/1ps
module sim_nor_status_resp;
    localparam int AW  = 12;
    localparam int PC  = 6;
    localparam int EC  = 16;
    localparam int PPC = 3;
    localparam int PEC = 10;

    typedef struct packed {
        logic          is_ers;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          prot;
        logic [15:0]   cycles;
        logic          b7;
        logic [AW-1:0] raddr;
        logic [7:0]    rexp;
    } vec_t;

    // op, addr, data, prot, busy cycles, busy bit7, read addr, read-back
    localparam vec_t VT [7] = '{
        '{1'b0, 12'h123, 8'hA5, 1'b0, 16'(PC),  1'b0, 12'h123, 8'hA5},  // R2 R3 R4
        '{1'b0, 12'h456, 8'h3C, 1'b1, 16'(PPC), 1'b1, 12'h456, 8'hFF},  // R5
        '{1'b0, 12'h456, 8'h3C, 1'b0, 16'(PC),  1'b1, 12'h456, 8'h3C},  // R2 R4
        '{1'b1, 12'h400, 8'h00, 1'b1, 16'(PEC), 1'b0, 12'h456, 8'h3C},  // R7
        '{1'b1, 12'h100, 8'h00, 1'b0, 16'(EC),  1'b0, 12'h456, 8'h3C},  // R6 outside
        '{1'b1, 12'h4FF, 8'h00, 1'b0, 16'(EC),  1'b0, 12'h456, 8'hFF},  // R6 inside
        '{1'b0, 12'h7AB, 8'h55, 1'b0, 16'(PC),  1'b1, 12'h7AB, 8'h55}   // R3 R4
    };

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          pgm_req = 0, ers_req = 0, sus_req = 0, res_req = 0, cmd_prot = 0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0]    cmd_data = '0, rd_data;
    logic          ready;
    int            nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    nor_status_resp #(.AW(AW), .SECW(4), .PROG_CYC(PC), .ERS_CYC(EC),
                      .PPROG_CYC(PPC), .PERS_CYC(PEC)) u0 (
        .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .ers_req(ers_req),
        .sus_req(sus_req), .res_req(res_req), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_prot(cmd_prot), .rd_addr(rd_addr),
        .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle request pulse; returns at the first busy cycle.
    task automatic issue(input logic ers, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic p);
        @(negedge clk);
        cmd_addr = a; cmd_data = d; cmd_prot = p;
        if (ers) ers_req = 1'b1; else pgm_req = 1'b1;
        @(negedge clk);
        ers_req = 1'b0; pgm_req = 1'b0;
    endtask

    // Count busy cycles while checking polling status each cycle.
    task automatic run_busy(input logic exp_b7, input string req, output int n);
        n = 0;
        while (ready !== 1'b1 && n < 1000) begin
            chk({req, " poll bit7"}, 32'(rd_data[7]), 32'(exp_b7));
            if (n > 0) chk({req, " low bits while busy"}, 32'(rd_data[6:0]), 0);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = 12'h123;
        @(negedge clk);
        chk("R1 ready after reset", 32'(ready), 1);
        chk("R1 read after reset", 32'(rd_data), 32'h FF);

        // Vector table walk
        for (int i = 0; i < 7; i++) begin
            rd_addr = VT[i].raddr;
            issue(VT[i].is_ers, VT[i].addr, VT[i].data, VT[i].prot);
            run_busy(VT[i].b7, "R3/R6 vector", n);
            chk("R2/R5/R6/R7 busy length", 32'(n), 32'(VT[i].cycles));
            chk("R4 first ready bit7 true", 32'(rd_data[7]), 32'(VT[i].rexp[7]));
            chk("R4 first ready low bits stale", 32'(rd_data[6:0]), 0);
            @(negedge clk);
            chk("R4/R5/R6/R7 read-back", 32'(rd_data), 32'(VT[i].rexp));
        end

        // R8: suspend erase of sector 7 after 5 busy cycles
        rd_addr = 12'h7AB;
        issue(1'b1, 12'h700, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        sus_req = 1'b1;
        @(negedge clk);
        sus_req = 1'b0;
        chk("R8 ready in suspend", 32'(ready), 1);
        @(negedge clk);
        chk("R8 suspended read in sector", 32'(rd_data), 32'h80);
        // R9: program inside erase sector ignored
        pgm_req = 1'b1; cmd_addr = 12'h7C0; cmd_data = 8'h00; cmd_prot = 1'b0;
        @(negedge clk);
        pgm_req = 1'b0;
        chk("R9 in-sector program ignored", 32'(ready), 1);
        // R9: program outside sector while suspended
        rd_addr = 12'h2AA;
        issue(1'b0, 12'h2AA, 8'h0F, 1'b0);
        run_busy(1'b1, "R9 suspended program", n);
        chk("R9 suspended program length", 32'(n), PC);
        @(negedge clk);
        chk("R9 suspended program read", 32'(rd_data), 32'h0F);
        // R10: erase while suspended ignored
        rd_addr = 12'h7AB;
        ers_req = 1'b1; cmd_addr = 12'h300;
        @(negedge clk);
        ers_req = 1'b0;
        @(negedge clk);
        chk("R10 erase in suspend ignored ready", 32'(ready), 1);
        chk("R10 still suspended", 32'(rd_data), 32'h80);
        // R8: resume, remaining erase cycles
        res_req = 1'b1;
        @(negedge clk);
        res_req = 1'b0;
        run_busy(1'b0, "R8 resumed erase", n);
        chk("R8 remaining erase cycles", 32'(n), EC - 5);
        rd_addr = 12'h2AA;
        @(negedge clk);
        @(negedge clk);
        chk("R8 data outside erase sector kept", 32'(rd_data), 32'h0F);

        // R11: suspend on final erase cycle loses to completion
        issue(1'b1, 12'h2FF, 8'h00, 1'b0);
        repeat (EC - 1) @(negedge clk);
        sus_req = 1'b1;
        @(negedge clk);
        sus_req = 1'b0;
        chk("R11 ready after last-cycle suspend", 32'(ready), 1);
        @(negedge clk);
        chk("R11 erase completed not suspended", 32'(rd_data), 32'hFF);

        // R10: suspend ignored during protected erase
        issue(1'b1, 12'h500, 8'h00, 1'b1);
        sus_req = 1'b1;
        @(negedge clk);
        sus_req = 1'b0;
        run_busy(1'b0, "R10 protected erase", n);
        chk("R10 suspend ignored in protected erase", 32'(n), PEC - 1);

        // R12: program wins over erase in idle
        rd_addr = 12'h333;
        @(negedge clk);
        pgm_req = 1'b1; ers_req = 1'b1; cmd_addr = 12'h333; cmd_data = 8'h12; cmd_prot = 1'b0;
        @(negedge clk);
        pgm_req = 1'b0; ers_req = 1'b0;
        run_busy(1'b1, "R12 priority", n);
        chk("R12 program wins length", 32'(n), PC);
        @(negedge clk);
        chk("R12 program wins data", 32'(rd_data), 32'h12);

        // R10: erase during program ignored
        rd_addr = 12'h444;
        issue(1'b0, 12'h444, 8'h21, 1'b0);
        ers_req = 1'b1; cmd_addr = 12'h400;
        @(negedge clk);
        ers_req = 1'b0;
        run_busy(1'b1, "R10 program", n);
        chk("R10 erase during program ignored", 32'(n), PC - 1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 ready stays after ignored erase", 32'(ready), 1);
        chk("R10 program data intact", 32'(rd_data), 32'h21);

        // R10: resume in idle ignored
        res_req = 1'b1;
        @(negedge clk);
        res_req = 1'b0;
        chk("R10 resume in idle ignored", 32'(ready), 1);

        // R13: low bits trail an address change by one cycle
        rd_addr = 12'h000;
        #1;
        chk("R13 low bits lag address", 32'(rd_data), 32'hA1);
        @(negedge clk);
        chk("R13 low bits caught up", 32'(rd_data), 32'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule